// File: doc/BRIEF.md
# Three-C Cache Miss Classifier

This block sits beside a direct-mapped cache and watches its access stream. For every access it receives the block address and whether the real cache hit. Each miss is given one of three labels. A miss is compulsory when the block has never been referenced since reset. It is a conflict miss when the block was referenced before and a fully associative directory of the same capacity would still hold it. It is a capacity miss when the block was referenced before but even that associative directory has lost it.

Two structures hold the history. A first-reference bit array covers the whole bounded block-address space and is cleared by reset. A shadow directory has as many lines as the real cache and uses true least-recently-used replacement. Both are updated on every access, hits included. A hit produces no label. Each label appears one cycle after its access. Three saturating counters keep running totals per class, and they can be read at any time while accesses continue.

Top module: `miss_classifier`

## Requirements
- R1: While reset is asserted and directly after it, `cls_valid` is 0 and all three counters read 0.
- R2: An access with `acc_hit`=1 drives `cls_valid` low in the following cycle and leaves all counters unchanged.
- R3: A miss on a block address never referenced since reset yields `cls_valid`=1 with `cls_kind`=1 (compulsory) in the cycle after the access.
- R4: A miss on a previously referenced block that is among the LINES most recently used distinct blocks yields `cls_kind`=3 (conflict).
- R5: A miss on a previously referenced block that is not among the LINES most recently used distinct blocks yields `cls_kind`=2 (capacity).
- R6: Every access, hit or miss, makes its block the most recently used entry of the shadow directory. When the directory is full, an insertion evicts the least recently used entry.
- R7: A hit on a block records it as referenced, so a later miss on that block is never compulsory.
- R8: Each counter holds at its all-ones value once reached and does not wrap.
- R9: Each label increments exactly the counter of its class (`cnt_cold`, `cnt_cap`, `cnt_conf`) on the same edge at which `cls_valid` rises. The counters are readable while accesses continue.
- R10: A reset clears the reference history, so a block seen before the reset is classified compulsory on its next miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Block address of the access |
| acc_hit | input | 1 | Result from the real cache: 1 = hit |
| cls_valid | output | 1 | A miss label is valid this cycle |
| cls_kind | output | 2 | 1 compulsory, 2 capacity, 3 conflict, 0 none |
| cnt_cold | output | CNT_W | Saturating count of compulsory misses |
| cnt_cap | output | CNT_W | Saturating count of capacity misses |
| cnt_conf | output | CNT_W | Saturating count of conflict misses |

## Verification
The hardest case to reach is a block whose recency depends only on a hit. Without the hit refresh it would have been evicted, and with it a different block falls out of the shadow directory. The stimulus fills the directory, hits its oldest entry and then inserts a new block. Misses that follow on the refreshed block and on the displaced block must then come out as conflict and capacity. Saturation is reached by running the bench with narrow counters and a long run of first-time misses.

// File: rtl/mc_pkg.sv
package mc_pkg;
   typedef enum logic [1:0] {
      KIND_NONE     = 2'd0,
      KIND_COLD     = 2'd1,
      KIND_CAPACITY = 2'd2,
      KIND_CONFLICT = 2'd3
   } miss_kind_e;

   localparam int NUM_CLASSES = 3;
endpackage

// File: rtl/mc_seen_tracker.sv
module mc_seen_tracker #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [ADDR_W-1:0] addr,
   output logic              seen
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0] seen_q;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_width
         $error("mc_seen_tracker: ADDR_W must lie in 1..12");
      end
   endgenerate

   assign seen = seen_q[addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
      end else if (upd) begin
         seen_q[addr] <= 1'b1;
      end
   end

   // R7
   mark_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> seen_q[$past(addr)]);
endmodule

// File: rtl/mc_lru_shadow.sv
module mc_lru_shadow #(
   parameter int ADDR_W = 8,
   parameter int LINES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   // Entry 0 is most recently used, entry LINES-1 least recently used.
   logic [ADDR_W-1:0] tag_q   [LINES];
   logic [LINES-1:0]  valid_q;
   logic [LINES-1:0]  match;
   logic [LINES-1:0]  at_or_after;
   logic [LINES-1:0]  shift_en;

   generate
      if (LINES < 1 || LINES > 64) begin : g_bad_lines
         $error("mc_lru_shadow: LINES must lie in 1..64");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < LINES; gi++) begin : g_match
         assign match[gi] = valid_q[gi] && (tag_q[gi] == addr);
      end
      assign at_or_after[LINES-1] = match[LINES-1];
      for (gi = LINES - 2; gi >= 0; gi--) begin : g_chain
         assign at_or_after[gi] = match[gi] | at_or_after[gi+1];
      end
   endgenerate

   assign hit      = |match;
   assign shift_en = hit ? at_or_after : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q[0] <= 1'b0;
         tag_q[0]   <= '0;
      end else if (upd) begin
         valid_q[0] <= 1'b1;
         tag_q[0]   <= addr;
      end
   end

   generate
      for (gi = 1; gi < LINES; gi++) begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q[gi] <= 1'b0;
               tag_q[gi]   <= '0;
            end else if (upd && shift_en[gi]) begin
               valid_q[gi] <= valid_q[gi-1];
               tag_q[gi]   <= tag_q[gi-1];
            end
         end
      end
   endgenerate

   // R6
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R6
   mru_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (valid_q[0] && tag_q[0] == $past(addr)));
endmodule

// File: rtl/mc_sat_counter.sv
module mc_sat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] MAX_VAL = '1;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("mc_sat_counter: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (inc && cnt != MAX_VAL) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R8
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == MAX_VAL) |=> (cnt == MAX_VAL));

   // R9
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && cnt != MAX_VAL) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/miss_classifier.sv
module miss_classifier #(
   parameter int ADDR_W = 8,
   parameter int LINES  = 4,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_hit,
   output logic              cls_valid,
   output logic [1:0]        cls_kind,
   output logic [CNT_W-1:0]  cnt_cold,
   output logic [CNT_W-1:0]  cnt_cap,
   output logic [CNT_W-1:0]  cnt_conf
);
   import mc_pkg::*;

   logic                  was_seen;
   logic                  in_shadow;
   logic                  is_miss;
   miss_kind_e            kind_now;
   miss_kind_e            kind_q;
   logic [NUM_CLASSES-1:0] class_inc;
   logic [CNT_W-1:0]      cnt_all [NUM_CLASSES];

   mc_seen_tracker #(.ADDR_W(ADDR_W)) u_seen (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (acc_valid),
      .addr (acc_addr),
      .seen (was_seen)
   );

   mc_lru_shadow #(.ADDR_W(ADDR_W), .LINES(LINES)) u_shadow (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (acc_valid),
      .addr (acc_addr),
      .hit  (in_shadow)
   );

   assign is_miss = acc_valid && !acc_hit;

   always_comb begin
      if (!was_seen)      kind_now = KIND_COLD;
      else if (in_shadow) kind_now = KIND_CONFLICT;
      else                kind_now = KIND_CAPACITY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls_valid <= 1'b0;
         kind_q    <= KIND_NONE;
      end else begin
         cls_valid <= is_miss;
         kind_q    <= is_miss ? kind_now : KIND_NONE;
      end
   end

   assign cls_kind = kind_q;

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CLASSES; gc++) begin : g_cnt
         assign class_inc[gc] = is_miss && (kind_now == miss_kind_e'(gc + 1));
         mc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (class_inc[gc]),
            .cnt  (cnt_all[gc])
         );
      end
   endgenerate

   assign cnt_cold = cnt_all[0];
   assign cnt_cap  = cnt_all[1];
   assign cnt_conf = cnt_all[2];

   // R2
   hit_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_hit) |=> !cls_valid);

   // R3
   miss_labelled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_miss |=> (cls_valid && cls_kind != KIND_NONE));

   // R9
   one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(class_inc));

   // R7
   seen_not_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_miss && in_shadow) |-> was_seen);
endmodule

// File: tb/sim_miss_classifier.sv
`timescale 1ns/1ps
module sim_miss_classifier;
   localparam int ADDR_W = 8;
   localparam int LINES  = 4;
   localparam int CNT_W  = 4;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_valid = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic              acc_hit = 1'b0;
   logic              cls_valid;
   logic [1:0]        cls_kind;
   logic [CNT_W-1:0]  cnt_cold, cnt_cap, cnt_conf;

   int checks = 0;
   int failures = 0;
   int exp_cnt [3];
   int    q_kind [$];
   string q_req  [$];

   always #10 clk = ~clk;

   miss_classifier #(.ADDR_W(ADDR_W), .LINES(LINES), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_hit(acc_hit), .cls_valid(cls_valid), .cls_kind(cls_kind),
      .cnt_cold(cnt_cold), .cnt_cap(cnt_cap), .cnt_conf(cnt_conf)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: one access per cycle; expected kind 0 means a hit (no label).
   task automatic access(input int a, input bit h, input int k, input string req);
      acc_valid = 1'b1;
      acc_addr  = ADDR_W'(a);
      acc_hit   = h;
      q_kind.push_back(k);
      q_req.push_back(req);
      @(negedge clk);
      acc_valid = 1'b0;
      acc_hit   = 1'b0;
   endtask

   task automatic do_reset();
      acc_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check(cls_valid == 1'b0, "R1 cls_valid in reset", int'(cls_valid), 0);
      check(cnt_cold == 0 && cnt_cap == 0 && cnt_conf == 0, "R1 counters in reset",
            int'(cnt_cold) + int'(cnt_cap) + int'(cnt_conf), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) exp_cnt[i] = 0;
      q_kind.delete();
      q_req.delete();
   endtask

   // Monitor: samples 5 ns after each rising edge.
   always @(posedge clk) begin
      #5;
      if (rst_n) begin
         if (q_kind.size() == 0) begin
            if (cls_valid) check(1'b0, "R2 unexpected label", int'(cls_kind), 0);
         end else begin
            int    k;
            string r;
            k = q_kind.pop_front();
            r = q_req.pop_front();
            if (k == 0) begin
               check(cls_valid == 1'b0, {r, " hit gives no label"}, int'(cls_valid), 0);
            end else begin
               check(cls_valid == 1'b1 && int'(cls_kind) == k, {r, " kind"},
                     int'(cls_kind), k);
               if (exp_cnt[k-1] < CMAX) exp_cnt[k-1]++;
            end
            check(int'(cnt_cold) == exp_cnt[0], {r, " R9 cnt_cold"}, int'(cnt_cold), exp_cnt[0]);
            check(int'(cnt_cap)  == exp_cnt[1], {r, " R9 cnt_cap"},  int'(cnt_cap),  exp_cnt[1]);
            check(int'(cnt_conf) == exp_cnt[2], {r, " R9 cnt_conf"}, int'(cnt_conf), exp_cnt[2]);
         end
      end
   end

   initial begin
      #400000;
      check(1'b0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R3: first references (kind 1 = compulsory)
      access(1, 0, 1, "R3");
      access(2, 0, 1, "R3");
      access(3, 0, 1, "R3");
      access(4, 0, 1, "R3");
      // R2/R6: hit refreshes block 1; order 1,4,3,2
      access(1, 1, 0, "R2");
      access(5, 0, 1, "R3");          // evicts 2; order 5,1,4,3
      access(1, 0, 3, "R6 R4");       // conflict; order 1,5,4,3
      access(2, 0, 2, "R6 R5");       // capacity; evicts 3; order 2,1,5,4
      access(4, 0, 3, "R4");          // order 4,2,1,5
      // R7: first reference is a hit, evicts 5; order 9,4,2,1
      access(9, 1, 0, "R7 R2");
      access(9, 0, 3, "R7");          // seen and resident: conflict
      access(5, 0, 2, "R5");          // capacity
      access(3, 0, 2, "R5");          // capacity
      // R8: many first references saturate the compulsory counter
      for (int a = 20; a < 40; a++) access(a, 0, 1, "R8");
      access(2, 0, 2, "R8 R5");       // other counters still move
      @(negedge clk);
      @(negedge clk);
      check(int'(cnt_cold) == CMAX, "R8 cnt_cold saturated", int'(cnt_cold), CMAX);
      // R10: reset clears history
      do_reset();
      @(negedge clk);
      access(1, 0, 1, "R10");
      access(9, 0, 1, "R10");
      access(1, 0, 3, "R10 R4");
      @(negedge clk);
      @(negedge clk);
      check(q_kind.size() == 0, "R9 scoreboard drained", q_kind.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule